// File: doc/BRIEF.md
# Occlusion-Masked Pixel Write Stage

This block is the last stage of a video output path, after scaling and colour conversion. It takes a stream of finished 32-bit RGB pixels, each labelled with its screen column and row. For each pixel it reads one visibility bit from a bitmap in memory. The bitmap is indexed by those screen coordinates, not by the coordinates of the source image. The pixel becomes a frame-buffer write only when that bit is one. When the bit is zero the pixel is dropped with no other effect, so any number of overlapping windows of any shape can be drawn without clipping to a rectangle.

The bitmap is packed 32 pixels per memory word. The block keeps one word cached and tagged with its row and word column. It fetches a new word through a read-request/response port only when the row or the 32-pixel column changes. While a fetch is in flight, input is stalled. A start pulse does three things: it latches the frame size, clears the counters of written and dropped pixels, and invalidates the cached word, so a bitmap that software has rewritten between frames is always read fresh. When the cache hits and the write port is ready, the stage accepts one pixel per clock.

Top module: `occl_write_stage`

## Requirements
- R1: A pixel accepted with visibility bit 1 produces exactly one write on the cycle after acceptance. The write address is `cfg_fb_base + y*cfg_fb_pitch + 4*x` and the data is the pixel's RGB word.
- R2: A pixel accepted with visibility bit 0 produces no write. It only increments the dropped counter.
- R3: The visibility bit for pixel (x, y) is bit `x[4:0]` of the mask word at address `cfg_mask_base + y*cfg_mask_stride + (x >> 5)`. Bit 0 is the leftmost pixel of the word.
- R4: A mask read is issued only when a presented pixel's row or word column differs from the cached word, or when no word is cached. Consecutive pixels that share a word cause no further read.
- R5: From the cycle a mask read is accepted through the cycle its response arrives, `pix_ready` is low. While `mrd_req_ready` is low, the request address is held.
- R6: While `fbw_valid` is high and `fbw_ready` is low, the write address and data are held. No new pixel is accepted while the write slot is full and not draining.
- R7: When the cached word matches and `fbw_ready` is high, the stage accepts one pixel every clock.
- R8: `cnt_written` and `cnt_dropped` count visible and dropped pixels. They change on the cycle after acceptance and are cleared by `start`.
- R9: `pix_ready` is low before the first start and after `cfg_width*cfg_height` pixels have been accepted. `done` rises on the cycle after the last of those pixels is accepted and stays high until the next start.
- R10: `start` invalidates the cached mask word, so the first pixel of every frame issues a read, even at the position cached in the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a frame: latch size, clear counters, flush cached mask word |
| cfg_width | input | CW | Pixels per line |
| cfg_height | input | CW | Lines per frame |
| cfg_mask_base | input | AW | Word address of the visibility bitmap |
| cfg_mask_stride | input | AW | Bitmap words per screen row |
| cfg_fb_base | input | AW | Byte address of the frame buffer |
| cfg_fb_pitch | input | AW | Frame-buffer bytes per screen row |
| pix_valid | input | 1 | Pixel present |
| pix_ready | output | 1 | Pixel accepted this cycle when high with pix_valid |
| pix_x | input | CW | Destination column |
| pix_y | input | CW | Destination row |
| pix_rgb | input | DW | Final pixel colour |
| mrd_req_valid | output | 1 | Mask read request |
| mrd_req_ready | input | 1 | Mask read request taken |
| mrd_req_addr | output | AW | Mask word address |
| mrd_rsp_valid | input | 1 | Mask read data present |
| mrd_rsp_data | input | MW | Mask word |
| fbw_valid | output | 1 | Frame-buffer write request |
| fbw_ready | input | 1 | Write request taken |
| fbw_addr | output | AW | Write byte address |
| fbw_data | output | DW | Write data |
| cnt_written | output | NW | Pixels written this frame |
| cnt_dropped | output | NW | Pixels suppressed this frame |
| done | output | 1 | Frame fully consumed |

## Verification
Each result has a fixed delay after the pixel is accepted. The frame-buffer write, the counter update and the rise of `done` all appear exactly one clock after acceptance. A mask read leaves the block one clock after a missing pixel is presented, and the stall lasts until one clock after its response. A behavioural model in the bench snapshots its expected write queue depth, counters and done flag in every cycle, and compares them in the following cycle, which is the cycle in which the registered outputs change. Readiness is sampled a quarter period after each falling edge. A pixel that hits the cached word with the write port ready must be taken on its first cycle.

// File: rtl/occl_pkg.sv
// Shared types for the occlusion-masked write stage.
package occl_pkg;
    // States of the mask word fetch engine.
    typedef enum logic [1:0] {
        MF_IDLE = 2'd0,
        MF_REQ  = 2'd1,
        MF_WAIT = 2'd2
    } mfetch_e;
endpackage

// File: rtl/occl_mask_cache.sv
// Single-entry cache of the visibility bitmap.
// Holds one MW-bit mask word tagged by row and word column. On a miss it
// issues one read and waits for the response. Assumes at most one read is
// outstanding and that the response arrives no earlier than the cycle after
// the request is taken. flush drops the cached word.
module occl_mask_cache
    import occl_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 12,
    parameter int MW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          lookup,
    input  logic [CW-1:0] px,
    input  logic [CW-1:0] py,
    input  logic [AW-1:0] mask_base,
    input  logic [AW-1:0] mask_stride,
    output logic          hit,
    output logic          vis_bit,
    output logic          busy,
    output logic          mrd_req_valid,
    input  logic          mrd_req_ready,
    output logic [AW-1:0] mrd_req_addr,
    input  logic          mrd_rsp_valid,
    input  logic [MW-1:0] mrd_rsp_data
);
    localparam int IDX_W = $clog2(MW);
    localparam int COL_W = CW - IDX_W;

    mfetch_e          st_q;
    logic [MW-1:0]    word_q;
    logic [CW-1:0]    tag_y_q, pend_y_q;
    logic [COL_W-1:0] tag_col_q, pend_col_q;
    logic             tag_ok_q;
    logic [AW-1:0]    addr_q;

    logic [COL_W-1:0] col;
    logic             tag_match;
    logic [AW-1:0]    word_addr;

    // Word column of the presented pixel and its bitmap word address.
    always_comb begin
        col       = px[CW-1:IDX_W];
        tag_match = tag_ok_q && (tag_y_q == py) && (tag_col_q == col);
        word_addr = mask_base + AW'(py) * mask_stride + AW'(col);
    end

    assign hit           = (st_q == MF_IDLE) && tag_match;
    assign vis_bit       = word_q[px[IDX_W-1:0]];
    assign busy          = (st_q != MF_IDLE);
    assign mrd_req_valid = (st_q == MF_REQ);
    assign mrd_req_addr  = addr_q;

    // Fetch engine: detect a miss, issue the read, capture the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= MF_IDLE;
            word_q     <= '0;
            tag_y_q    <= '0;
            tag_col_q  <= '0;
            tag_ok_q   <= 1'b0;
            pend_y_q   <= '0;
            pend_col_q <= '0;
            addr_q     <= '0;
        end else begin
            case (st_q)
                MF_IDLE: begin
                    if (lookup && !flush && !tag_match) begin
                        st_q       <= MF_REQ;
                        addr_q     <= word_addr;
                        pend_y_q   <= py;
                        pend_col_q <= col;
                    end
                end
                MF_REQ: begin
                    if (mrd_req_ready) begin
                        st_q <= MF_WAIT;
                    end
                end
                MF_WAIT: begin
                    if (mrd_rsp_valid) begin
                        st_q      <= MF_IDLE;
                        word_q    <= mrd_rsp_data;
                        tag_y_q   <= pend_y_q;
                        tag_col_q <= pend_col_q;
                        tag_ok_q  <= 1'b1;
                    end
                end
                default: st_q <= MF_IDLE;
            endcase
            if (flush) begin
                tag_ok_q <= 1'b0;
            end
        end
    end

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mrd_req_valid && !mrd_req_ready) |=> (mrd_req_valid && $stable(mrd_req_addr)));

    // R5
    wait_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mrd_req_valid && mrd_req_ready) |=> !hit);
endmodule

// File: rtl/occl_fb_port.sv
// Single-slot frame-buffer write request register.
// Loads one pixel's write (address derived from screen coordinates, data)
// and holds it until the write port takes it. slot_free tells the upstream
// logic that a load may happen this cycle.
module occl_fb_port #(
    parameter int AW = 32,
    parameter int CW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] px,
    input  logic [CW-1:0] py,
    input  logic [DW-1:0] rgb,
    input  logic [AW-1:0] fb_base,
    input  logic [AW-1:0] fb_pitch,
    output logic          slot_free,
    output logic          fbw_valid,
    input  logic          fbw_ready,
    output logic [AW-1:0] fbw_addr,
    output logic [DW-1:0] fbw_data
);
    localparam int BYTE_SH = $clog2(DW / 8);

    logic [AW-1:0] pix_addr;

    // Byte address of the pixel in the frame buffer.
    always_comb begin
        pix_addr = fb_base + AW'(py) * fb_pitch + (AW'(px) << BYTE_SH);
    end

    assign slot_free = !fbw_valid || fbw_ready;

    // Write slot: load on acceptance, release when the port takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fbw_valid <= 1'b0;
            fbw_addr  <= '0;
            fbw_data  <= '0;
        end else if (load) begin
            fbw_valid <= 1'b1;
            fbw_addr  <= pix_addr;
            fbw_data  <= rgb;
        end else if (fbw_ready) begin
            fbw_valid <= 1'b0;
        end
    end

    // R6
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fbw_valid && !fbw_ready) |=> (fbw_valid && $stable(fbw_addr) && $stable(fbw_data)));
endmodule

// File: rtl/occl_frame_ctl.sv
// Frame sequencing and statistics.
// start latches width*height, clears the counters and opens the frame.
// Each accepted pixel is counted as written or dropped; the frame closes
// and done rises after the last pixel. Assumes NW >= 2*CW.
module occl_frame_ctl #(
    parameter int CW = 12,
    parameter int NW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] width,
    input  logic [CW-1:0] height,
    input  logic          accept,
    input  logic          vis,
    output logic          running,
    output logic          done,
    output logic [NW-1:0] cnt_written,
    output logic [NW-1:0] cnt_dropped
);
    logic [NW-1:0] total_q, acc_q, tot;

    // Pixel count of the frame being started.
    always_comb begin
        tot = NW'(width) * NW'(height);
    end

    // Frame state, accepted-pixel count and visibility statistics.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total_q     <= '0;
            acc_q       <= '0;
            running     <= 1'b0;
            done        <= 1'b0;
            cnt_written <= '0;
            cnt_dropped <= '0;
        end else if (start) begin
            total_q     <= tot;
            acc_q       <= '0;
            running     <= (tot != '0);
            done        <= (tot == '0);
            cnt_written <= '0;
            cnt_dropped <= '0;
        end else if (accept) begin
            acc_q <= acc_q + 1'b1;
            if (vis) begin
                cnt_written <= cnt_written + 1'b1;
            end else begin
                cnt_dropped <= cnt_dropped + 1'b1;
            end
            if (acc_q + 1'b1 == total_q) begin
                running <= 1'b0;
                done    <= 1'b1;
            end
        end
    end

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !start) |=> ((cnt_written + cnt_dropped) == ($past(cnt_written + cnt_dropped) + 1'b1)));

    // R9
    done_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !running);
endmodule

// File: rtl/occl_write_stage.sv
// Occlusion-masked pixel write stage (top).
// Accepts screen-addressed RGB pixels, looks up each pixel's visibility bit
// through a one-word mask cache, and forwards visible pixels as frame-buffer
// writes. Assumes configuration inputs are stable for the length of a frame
// and that software edits the bitmap only between frames.
module occl_write_stage #(
    parameter int AW = 32,
    parameter int CW = 12,
    parameter int NW = 24,
    parameter int MW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] cfg_width,
    input  logic [CW-1:0] cfg_height,
    input  logic [AW-1:0] cfg_mask_base,
    input  logic [AW-1:0] cfg_mask_stride,
    input  logic [AW-1:0] cfg_fb_base,
    input  logic [AW-1:0] cfg_fb_pitch,
    input  logic          pix_valid,
    output logic          pix_ready,
    input  logic [CW-1:0] pix_x,
    input  logic [CW-1:0] pix_y,
    input  logic [DW-1:0] pix_rgb,
    output logic          mrd_req_valid,
    input  logic          mrd_req_ready,
    output logic [AW-1:0] mrd_req_addr,
    input  logic          mrd_rsp_valid,
    input  logic [MW-1:0] mrd_rsp_data,
    output logic          fbw_valid,
    input  logic          fbw_ready,
    output logic [AW-1:0] fbw_addr,
    output logic [DW-1:0] fbw_data,
    output logic [NW-1:0] cnt_written,
    output logic [NW-1:0] cnt_dropped,
    output logic          done
);
    logic running, hit, vis_bit, mask_busy, slot_free, accept;

    // Acceptance: frame open, mask word present, write slot available.
    always_comb begin
        pix_ready = running && !start && hit && slot_free;
        accept    = pix_valid && pix_ready;
    end

    occl_mask_cache #(.AW(AW), .CW(CW), .MW(MW)) mask_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (start),
        .lookup       (pix_valid && running),
        .px           (pix_x),
        .py           (pix_y),
        .mask_base    (cfg_mask_base),
        .mask_stride  (cfg_mask_stride),
        .hit          (hit),
        .vis_bit      (vis_bit),
        .busy         (mask_busy),
        .mrd_req_valid(mrd_req_valid),
        .mrd_req_ready(mrd_req_ready),
        .mrd_req_addr (mrd_req_addr),
        .mrd_rsp_valid(mrd_rsp_valid),
        .mrd_rsp_data (mrd_rsp_data)
    );

    occl_fb_port #(.AW(AW), .CW(CW), .DW(DW)) wr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept && vis_bit),
        .px       (pix_x),
        .py       (pix_y),
        .rgb      (pix_rgb),
        .fb_base  (cfg_fb_base),
        .fb_pitch (cfg_fb_pitch),
        .slot_free(slot_free),
        .fbw_valid(fbw_valid),
        .fbw_ready(fbw_ready),
        .fbw_addr (fbw_addr),
        .fbw_data (fbw_data)
    );

    occl_frame_ctl #(.CW(CW), .NW(NW)) ctl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .width      (cfg_width),
        .height     (cfg_height),
        .accept     (accept),
        .vis        (vis_bit),
        .running    (running),
        .done       (done),
        .cnt_written(cnt_written),
        .cnt_dropped(cnt_dropped)
    );

    // R5
    fetch_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_busy |-> !pix_ready);

    // R9
    closed_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !pix_ready);

    // R4
    miss_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mrd_req_valid) |-> $past(pix_valid && !pix_ready));

    // R1
    vis_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && vis_bit) |=> (fbw_valid && fbw_data == $past(pix_rgb)));

    // R2
    drop_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !vis_bit) |=> !fbw_valid);
endmodule

// File: tb/occl_write_stage_tb.sv
// Bench for occl_write_stage: behavioural reference compared every clock.
module occl_write_stage_tb_top;
    localparam int AW = 32;
    localparam int CW = 12;
    localparam int NW = 24;
    localparam int MW = 32;
    localparam int DW = 32;
    localparam int MB = 16;
    localparam int MS = 2;
    localparam logic [31:0] FBB = 32'h1000_0000;
    localparam int FBP = 256;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CW-1:0] cfg_width = '0, cfg_height = '0;
    logic [AW-1:0] cfg_mask_base = AW'(MB), cfg_mask_stride = AW'(MS);
    logic [AW-1:0] cfg_fb_base = FBB, cfg_fb_pitch = AW'(FBP);
    logic pix_valid = 1'b0;
    logic pix_ready;
    logic [CW-1:0] pix_x = '0, pix_y = '0;
    logic [DW-1:0] pix_rgb = '0;
    logic mrd_req_valid;
    logic mrd_req_ready = 1'b1;
    logic [AW-1:0] mrd_req_addr;
    logic mrd_rsp_valid = 1'b0;
    logic [MW-1:0] mrd_rsp_data = '0;
    logic fbw_valid;
    logic fbw_ready = 1'b1;
    logic [AW-1:0] fbw_addr;
    logic [DW-1:0] fbw_data;
    logic [NW-1:0] cnt_written, cnt_dropped;
    logic done;

    occl_write_stage #(.AW(AW), .CW(CW), .NW(NW), .MW(MW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_width(cfg_width), .cfg_height(cfg_height),
        .cfg_mask_base(cfg_mask_base), .cfg_mask_stride(cfg_mask_stride),
        .cfg_fb_base(cfg_fb_base), .cfg_fb_pitch(cfg_fb_pitch),
        .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_x(pix_x), .pix_y(pix_y), .pix_rgb(pix_rgb),
        .mrd_req_valid(mrd_req_valid), .mrd_req_ready(mrd_req_ready),
        .mrd_req_addr(mrd_req_addr), .mrd_rsp_valid(mrd_rsp_valid),
        .mrd_rsp_data(mrd_rsp_data),
        .fbw_valid(fbw_valid), .fbw_ready(fbw_ready),
        .fbw_addr(fbw_addr), .fbw_data(fbw_data),
        .cnt_written(cnt_written), .cnt_dropped(cnt_dropped), .done(done)
    );

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] mmem [0:255];
    logic [31:0] exp_mrd[$];
    logic [31:0] exp_fa[$];
    logic [31:0] exp_fd[$];
    int acc_cnt = 0, total = 0, exp_w = 0, exp_d = 0, mrd_seen = 0;
    int snap_w = 0, snap_d = 0, pend_snap = 0, rsp_wait = 0;
    bit snap_done = 0, started = 0, mon_on = 0, rdy_rand = 0, fetch_busy = 0;
    logic [31:0] rsp_addr = '0;
    bit m_ok = 0;
    int m_y = 0, m_col = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Memory responder, port readiness and per-clock comparison.
    always begin
        @(negedge clk);
        mrd_rsp_valid = 1'b0;
        if (rsp_wait > 0) begin
            rsp_wait--;
            if (rsp_wait == 0) begin
                mrd_rsp_valid = 1'b1;
                mrd_rsp_data  = mmem[rsp_addr[7:0]];
            end
        end
        fbw_ready     = rdy_rand ? (($urandom % 3) != 0) : 1'b1;
        mrd_req_ready = rdy_rand ? (($urandom % 2) != 0) : 1'b1;
        #3;
        if (mon_on) begin
            // R1 / R6: a write is pending exactly when the model has one
            chk(fbw_valid == (pend_snap > 0), "R1", "fbw_valid", fbw_valid, pend_snap > 0);
            if (fbw_valid && fbw_ready) begin
                if (exp_fa.size() == 0) begin
                    chk(0, "R2", "unexpected write", fbw_addr, 0);
                end else begin
                    chk(fbw_addr == exp_fa[0], "R1", "write addr", fbw_addr, exp_fa[0]);
                    chk(fbw_data == exp_fd[0], "R1", "write data", fbw_data, exp_fd[0]);
                    void'(exp_fa.pop_front());
                    void'(exp_fd.pop_front());
                end
            end
            pend_snap = exp_fa.size();
            if (mrd_req_valid && mrd_req_ready) begin
                mrd_seen++;
                fetch_busy = 1;
                rsp_wait   = 2;
                rsp_addr   = mrd_req_addr;
                if (exp_mrd.size() == 0) begin
                    chk(0, "R4", "unexpected mask read", mrd_req_addr, 0);
                end else begin
                    chk(mrd_req_addr == exp_mrd[0], "R3", "mask addr", mrd_req_addr, exp_mrd[0]);
                    void'(exp_mrd.pop_front());
                end
            end
            if (fetch_busy) begin
                chk(!pix_ready, "R5", "ready during fetch", pix_ready, 0);
            end
            if (mrd_rsp_valid) fetch_busy = 0;
            chk(done == snap_done, "R9", "done", done, snap_done);
            chk(cnt_written == NW'(snap_w), "R8", "cnt_written", cnt_written, snap_w);
            chk(cnt_dropped == NW'(snap_d), "R8", "cnt_dropped", cnt_dropped, snap_d);
            snap_done = started && (acc_cnt == total);
            snap_w = exp_w;
            snap_d = exp_d;
        end
    end

    task automatic start_frame(input int w, input int h);
        cfg_width  = CW'(w);
        cfg_height = CW'(h);
        start      = 1'b1;
        m_ok = 0;              // R10: cache model flushed by start
        acc_cnt = 0; total = w * h; exp_w = 0; exp_d = 0; mrd_seen = 0;
        started = 1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_pix(input int x, input int y, input logic [31:0] rgb, input bit fast);
        int wa;
        int tries;
        bit vis;
        bit must_fast;
        must_fast = fast;
        wa = MB + y * MS + x / 32;
        if (!(m_ok && m_y == y && m_col == x / 32)) begin
            exp_mrd.push_back(32'(wa));
            m_ok = 1; m_y = y; m_col = x / 32;
            must_fast = 0;
        end
        vis = mmem[wa][x % 32];
        pix_valid = 1'b1;
        pix_x = CW'(x);
        pix_y = CW'(y);
        pix_rgb = rgb;
        tries = 0;
        forever begin
            #2;
            if (pix_ready) break;
            tries++;
            @(negedge clk);
        end
        if (must_fast) chk(tries == 0, "R7", "stall on hit", tries, 0);
        acc_cnt++;
        if (vis) begin
            exp_fa.push_back(FBB + 32'(y * FBP) + 32'(x * 4));
            exp_fd.push_back(rgb);
            exp_w++;
        end else begin
            exp_d++;
        end
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    task automatic settle_and_check(input int reads, input string req);
        repeat (8) @(negedge clk);
        #3;
        chk(done == 1'b1, "R9", "done after frame", done, 1);
        chk(mrd_seen == reads, req, "mask reads in frame", mrd_seen, reads);
        chk(exp_mrd.size() == 0, "R4", "reads outstanding", exp_mrd.size(), 0);
        chk(exp_fa.size() == 0, "R1", "writes outstanding", exp_fa.size(), 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_bad++;
        n_vec++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mmem[i] = 32'hA5C3_0F69 ^ (32'(i) * 32'h0101_0107);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #3;
        // R9: reset state
        chk(!pix_ready, "R9", "ready after reset", pix_ready, 0);
        chk(!fbw_valid, "R1", "fbw_valid after reset", fbw_valid, 0);
        chk(!mrd_req_valid, "R4", "mrd after reset", mrd_req_valid, 0);
        chk(!done, "R9", "done after reset", done, 0);
        chk(cnt_written == '0 && cnt_dropped == '0, "R8", "counters after reset", cnt_written, 0);
        @(negedge clk);
        mon_on = 1;

        // R9: pixels offered before any start are not taken
        pix_valid = 1'b1; pix_x = 12'd3; pix_y = 12'd0; pix_rgb = 32'hDEAD_BEEF;
        for (int k = 0; k < 5; k++) begin
            #2;
            chk(!pix_ready, "R9", "ready before start", pix_ready, 0);
            @(negedge clk);
        end
        pix_valid = 1'b0;
        @(negedge clk);

        // Frame A: raster, ports always ready (R1 R2 R3 R4 R7)
        rdy_rand = 0;
        start_frame(40, 3);
        for (int y = 0; y < 3; y++)
            for (int x = 0; x < 40; x++)
                send_pix(x, y, {8'h11, 8'(y), 8'(x), 8'h5A}, 1'b1);
        settle_and_check(6, "R4");

        // Frame B: bitmap rewritten, random backpressure and gaps (R6 R10)
        for (int i = 0; i < 256; i++) mmem[i] = ~mmem[i];
        rdy_rand = 1;
        start_frame(40, 3);
        for (int y = 0; y < 3; y++)
            for (int x = 0; x < 40; x++) begin
                send_pix(x, y, {8'h22, 8'(y), 8'(x), 8'hC3}, 1'b0);
                if (($urandom % 4) == 0) @(negedge clk);
            end
        settle_and_check(6, "R4");

        // Frame C: same word as cached at end of B, descending x (R10)
        mmem[MB + 2 * MS + 1] = 32'hFFFF_FFFF;
        rdy_rand = 0;
        start_frame(4, 1);
        for (int x = 39; x >= 36; x--) send_pix(x, 2, {8'h33, 8'd2, 8'(x), 8'h0F}, 1'b0);
        settle_and_check(1, "R10");
        chk(cnt_written == NW'(4), "R10", "written with fresh word", cnt_written, 4);

        // Frame D: fully occluded region with gaps (R2 R8)
        for (int i = MB; i < MB + 4; i++) mmem[i] = 32'h0;
        rdy_rand = 1;
        start_frame(8, 2);
        for (int y = 0; y < 2; y++)
            for (int x = 0; x < 8; x++) begin
                send_pix(x, y, {8'h44, 8'(y), 8'(x), 8'h99}, 1'b0);
                if (x % 3 == 0) @(negedge clk);
            end
        settle_and_check(2, "R4");
        #3;
        chk(cnt_dropped == NW'(16), "R2", "all dropped", cnt_dropped, 16);
        chk(cnt_written == '0, "R2", "none written", cnt_written, 0);
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule